// File: doc/BRIEF.md
# Sampled Phase-Frequency Detector with Lock Indicator

This block compares two divided-down pulse trains: one from the reference chain and one from the feedback chain of a frequency synthesiser. Both trains are brought onto a fast sampling clock. The block turns the timing gap between their rising edges into a pump-up or pump-down pulse, and that pulse lasts as many sampling cycles as the gap. All three outputs are active-low, in the style of open-drain pins. The charge pump and the loop filter sit outside the block.

The core is a four-state machine. In state `ST_IDLE` neither pump is driven. In `ST_UP` the reference edge has arrived and the block waits for the feedback edge. In `ST_DN` the feedback edge has arrived and the block waits for the reference edge. `ST_BOTH` is a single cycle in which both pumps are driven, entered when both edges land in the same cycle.

The transitions are named as follows:
- `T_REF` (IDLE→UP) and `T_FB` (IDLE→DN) fire on a lone edge.
- `T_COIN` (IDLE→BOTH) fires on coincident edges.
- `T_CLOSE` (UP/DN→IDLE) fires on the opposite edge.
- `T_RESTART` (UP→UP or DN→DN) fires when the closing edge and a fresh leading edge land together.
- `T_RELEASE` (BOTH→IDLE, UP, DN or BOTH) fires on the cycle after BOTH.

While the machine waits in UP or DN, further edges of the leading input have no effect. A slip of more than one period therefore wraps around rather than saturating. A lock monitor measures the width of each comparison. It asserts lock after a run of consecutive narrow comparisons and drops it at the end of the first wide one.

Top module: `phase_freq_detector`

## Requirements
- R1: Each input passes through a two-stage synchroniser. Only the rising edge of each input counts: a pulse held high for many cycles starts exactly one comparison.
- R2: When the reference edge leads the feedback edge by d sampling cycles (d ≥ 1), `up_n` is low for exactly d consecutive cycles and `dn_n` stays high.
- R3: When the feedback edge leads the reference edge by d cycles, `dn_n` is low for exactly d consecutive cycles and `up_n` stays high.
- R4: Edges that are detected in the same cycle drive `up_n` and `dn_n` low together for exactly one cycle.
- R5: While an up (or down) comparison is open, further edges of the leading input are ignored. With the feedback lagging by one period plus x cycles, the first up pulse spans period+x and every later one spans x.
- R6: `lock_n` goes low when a comparison closes and it is the fourth consecutive comparison whose pump pulse is at most 2 cycles wide. It is still high after the third such comparison, and a run of 3-cycle comparisons never sets it.
- R7: When a comparison wider than 2 cycles closes, `lock_n` returns high at the same point.
- R8: While `rst_n` is low, the machine is in IDLE, the lock count is cleared, and `up_n`, `dn_n` and `lock_n` are all high. Input activity during reset starts no comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pulse | input | 1 | Divided reference pulse train |
| fb_pulse | input | 1 | Divided feedback pulse train |
| up_n | output | 1 | Pump-up request, active low |
| dn_n | output | 1 | Pump-down request, active low |
| lock_n | output | 1 | Lock indication, active low |

## Verification
The assertions take for granted that each input stays high for at least one sampling cycle and low for at least one cycle between pulses. Under that condition the edge detectors never fire in two adjacent cycles. The minimum-width check on coincident edges, and the checks on open comparisons, rely on that single-cycle spacing of edges. The stimulus keeps each input high for 3 to 8 cycles, with periods of 16 or 20 cycles. It also drives the inputs low before every reset release, so no edge appears in a cycle the assertions do not expect.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_UP   = 2'd1,
        ST_DN   = 2'd2,
        ST_BOTH = 2'd3
    } pfd_state_e;

    localparam int NUM_INPUTS = 2;
    localparam int IDX_REF    = 0;
    localparam int IDX_FB     = 1;
endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] shift_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
            last_q  <= 1'b0;
        end else begin
            shift_q <= {shift_q[STAGES-2:0], din};
            last_q  <= shift_q[STAGES-1];
        end
    end

    assign rise = shift_q[STAGES-1] & ~last_q;

    // R1: a detected edge never repeats in the following cycle
    p_edge_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ref_edge,
    input  logic fb_edge,
    output logic up_n,
    output logic dn_n,
    output logic cmp_active,
    output logic cmp_end
);
    pfd_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        cmp_end = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (ref_edge && fb_edge)  state_d = ST_BOTH;  // T_COIN
                else if (ref_edge)        state_d = ST_UP;    // T_REF
                else if (fb_edge)         state_d = ST_DN;    // T_FB
            end
            ST_UP: begin
                if (fb_edge) begin
                    cmp_end = 1'b1;
                    state_d = ref_edge ? ST_UP : ST_IDLE;     // T_RESTART / T_CLOSE
                end
            end
            ST_DN: begin
                if (ref_edge) begin
                    cmp_end = 1'b1;
                    state_d = fb_edge ? ST_DN : ST_IDLE;      // T_RESTART / T_CLOSE
                end
            end
            ST_BOTH: begin
                cmp_end = 1'b1;                               // T_RELEASE
                if (ref_edge && fb_edge)  state_d = ST_BOTH;
                else if (ref_edge)        state_d = ST_UP;
                else if (fb_edge)         state_d = ST_DN;
                else                      state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        up_n       = !(state_q == ST_UP || state_q == ST_BOTH);
        dn_n       = !(state_q == ST_DN || state_q == ST_BOTH);
        cmp_active = (state_q != ST_IDLE);
    end

    // R4: joint drive lasts a single cycle
    p_both_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!up_n && !dn_n) |=> !(!up_n && !dn_n));
    // R2: lone feedback edge closes an up comparison
    p_up_close_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UP && fb_edge && !ref_edge) |=> up_n);
    // R3: lone reference edge closes a down comparison
    p_dn_close_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DN && ref_edge && !fb_edge) |=> dn_n);
    // R5: up stays asserted until the feedback edge, whatever the reference does
    p_up_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UP && !fb_edge) |=> !up_n);
endmodule

// File: rtl/pfd_lock_mon.sv
module pfd_lock_mon #(
    parameter int WIN_MAX   = 2,
    parameter int RUN_COUNT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_active,
    input  logic cmp_end,
    output logic lock_n
);
    localparam int WW = $clog2(WIN_MAX + 2) + 1;
    localparam int GW = $clog2(RUN_COUNT + 1);
    localparam logic [WW-1:0] WSAT  = WW'(WIN_MAX + 1);
    localparam logic [GW-1:0] GFULL = GW'(RUN_COUNT);

    logic [WW-1:0] width_q;
    logic [WW:0]   width_now;
    logic [GW-1:0] good_q;
    logic          narrow;
    logic          locked;

    assign width_now = {1'b0, width_q} + 1'b1;
    assign narrow    = (width_now <= (WW+1)'(WIN_MAX));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            width_q <= '0;
            good_q  <= '0;
        end else begin
            if (cmp_end)
                width_q <= '0;
            else if (cmp_active && width_q != WSAT)
                width_q <= width_q + 1'b1;

            if (cmp_end) begin
                if (!narrow)              good_q <= '0;
                else if (good_q != GFULL) good_q <= good_q + 1'b1;
            end
        end
    end

    assign locked = (good_q == GFULL);
    assign lock_n = ~locked;

    // R6: lock only rises at the close of a comparison
    p_lock_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(cmp_end));
    // R7: a wide comparison clears lock
    p_lock_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_end && !narrow) |=> !locked);
endmodule

// File: rtl/phase_freq_detector.sv
module phase_freq_detector
    import pfd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int LOCK_WIN    = 2,
    parameter int LOCK_RUN    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_pulse,
    input  logic fb_pulse,
    output logic up_n,
    output logic dn_n,
    output logic lock_n
);
    logic [NUM_INPUTS-1:0] raw_in;
    logic [NUM_INPUTS-1:0] rise;
    logic                  cmp_active;
    logic                  cmp_end;

    assign raw_in[IDX_REF] = ref_pulse;
    assign raw_in[IDX_FB]  = fb_pulse;

    for (genvar i = 0; i < NUM_INPUTS; i++) begin : g_sync
        pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_in[i]),
            .rise (rise[i])
        );
    end

    pfd_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_edge  (rise[IDX_REF]),
        .fb_edge   (rise[IDX_FB]),
        .up_n      (up_n),
        .dn_n      (dn_n),
        .cmp_active(cmp_active),
        .cmp_end   (cmp_end)
    );

    pfd_lock_mon #(.WIN_MAX(LOCK_WIN), .RUN_COUNT(LOCK_RUN)) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_active(cmp_active),
        .cmp_end   (cmp_end),
        .lock_n    (lock_n)
    );

    // R8: nothing is driven in the cycle after reset is released
    p_reset_quiet_r8: assert property (@(posedge clk)
        $rose(rst_n) |-> (up_n && dn_n && lock_n));
endmodule

// File: tb/sim_phase_freq_detector.sv
module sim_phase_freq_detector;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_pulse = 1'b0;
    logic fb_pulse = 1'b0;
    logic up_n, dn_n, lock_n;

    int n_checks = 0;
    int n_errors = 0;
    int up_w [64];
    int up_lk[64];
    int dn_w [64];
    int n_up, n_dn, both_cnt;

    always #10 clk = ~clk;

    phase_freq_detector u0 (
        .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
        .up_n(up_n), .dn_n(dn_n), .lock_n(lock_n)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ref_pulse = 1'b0;
        fb_pulse = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // Drives nr reference and nf feedback pulses; records pump pulse widths.
    task automatic run_pulses(int per, int ro, int fo, int hi, int nr, int nf);
        int up_run = 0;
        int dn_run = 0;
        int last_t = (ro + nr*per > fo + nf*per) ? ro + nr*per : fo + nf*per;
        n_up = 0; n_dn = 0; both_cnt = 0;
        for (int t = 0; t < last_t + 16; t++) begin
            @(negedge clk);
            if (!up_n && !dn_n) both_cnt++;
            if (!up_n) up_run++;
            else if (up_run > 0) begin
                if (n_up < 64) begin up_w[n_up] = up_run; up_lk[n_up] = lock_n; end
                n_up++; up_run = 0;
            end
            if (!dn_n) dn_run++;
            else if (dn_run > 0) begin
                if (n_dn < 64) dn_w[n_dn] = dn_run;
                n_dn++; dn_run = 0;
            end
            ref_pulse = (t >= ro) && (t < ro + nr*per) && (((t - ro) % per) < hi);
            fb_pulse  = (t >= fo) && (t < fo + nf*per) && (((t - fo) % per) < hi);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            ref_pulse = (i < 3);
            fb_pulse  = 1'b0;
        end
        chk("R8", "up_n in reset", up_n, 1);
        chk("R8", "dn_n in reset", dn_n, 1);
        chk("R8", "lock_n in reset", lock_n, 1);
        ref_pulse = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) @(negedge clk);
        chk("R8", "up_n after release", up_n, 1);
        chk("R8", "dn_n after release", dn_n, 1);
    endtask

    task automatic t_ref_leads();
        do_reset();
        run_pulses(16, 1, 4, 3, 3, 3);
        chk("R2", "up pulse count", n_up, 3);
        chk("R2", "up width", up_w[1], 3);
        chk("R2", "dn pulse count", n_dn, 0);
    endtask

    task automatic t_fb_leads();
        do_reset();
        run_pulses(16, 6, 2, 3, 3, 3);
        chk("R3", "dn pulse count", n_dn, 3);
        chk("R3", "dn width", dn_w[2], 4);
        chk("R3", "up pulse count", n_up, 0);
    endtask

    task automatic t_long_high();
        do_reset();
        run_pulses(20, 0, 3, 8, 2, 2);
        chk("R1", "one up pulse per period", n_up, 2);
        chk("R1", "up width with long high", up_w[0], 3);
    endtask

    task automatic t_coincident();
        do_reset();
        run_pulses(16, 2, 2, 3, 4, 4);
        chk("R4", "both-low cycles", both_cnt, 4);
        chk("R4", "up width", up_w[0], 1);
        chk("R4", "dn width", dn_w[3], 1);
        chk("R6", "lock after 4 coincident", up_lk[3], 0);
    endtask

    task automatic t_wrap();
        do_reset();
        run_pulses(20, 0, 25, 3, 5, 4);
        chk("R5", "up pulse count", n_up, 4);
        chk("R5", "first width spans slip", up_w[0], 25);
        chk("R5", "wrapped width 2", up_w[1], 5);
        chk("R5", "wrapped width 4", up_w[3], 5);
        chk("R5", "no down pulse", n_dn, 0);
    endtask

    task automatic t_lock();
        do_reset();
        run_pulses(16, 2, 3, 3, 6, 6);
        chk("R6", "no lock after 3rd", up_lk[2], 1);
        chk("R6", "lock at 4th", up_lk[3], 0);
        chk("R6", "lock held at 6th", up_lk[5], 0);
        run_pulses(16, 2, 7, 3, 1, 1);
        chk("R7", "wide width", up_w[0], 5);
        chk("R7", "lock drops", up_lk[0], 1);
        do_reset();
        run_pulses(16, 2, 4, 3, 6, 6);
        chk("R6", "width 2 locks", up_lk[5], 0);
        do_reset();
        run_pulses(16, 2, 5, 3, 6, 6);
        chk("R6", "width 3 never locks", up_lk[5], 1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_ref_leads();
        t_fb_leads();
        t_long_high();
        t_coincident();
        t_wrap();
        t_lock();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule